// File: doc/BRIEF.md
# Dual-Role Strap and Link-LED Pin Controller

This block owns two chip pads that have two jobs. While the chip is in reset and for one cycle after it, the pads carry board-level strap resistors that select the crystal frequency. After that they drive active-low link LEDs. The block releases both pads while reset is held. It samples their synchronized levels on the first clock after reset is released and keeps the result as a 2-bit frequency code inside a read-only trap word. For a fixed number of cycles it then drives the pads with the inverted code. After that window it hands each pad to its port's link indicator, gated by a single LED enable input.

The captured code changes only at the next reset. The frequency code is decoded elsewhere. If a pad is driven high from outside at the capture instant, the code reads as 25 MHz instead of the strapped value. The only way to recover is a fresh reset with the pads quiet.

Top module: `strap_led_pins`

## Requirements
- R1: While `rst_n` is low, `pad_oe` is 2'b00 for every value of `led_en` and `link_up`.
- R2: In the first cycle after `rst_n` rises, before the capturing clock edge, `pad_oe` stays 2'b00.
- R3: On the first rising clock edge with `rst_n` high, the synchronized level of pad 1 is stored in trap bit 10 and pad 0 in trap bit 9. The codes are 01 = 20 MHz, 10 = 40 MHz and 11 = 25 MHz, and a pad held high at that edge reads as 1.
- R4: `trap_word` equals 16'h79CF with the code in bits 10:9. For example, code 10 gives 16'h7DCF and code 11 gives 16'h7FCF.
- R5: After capture, changes on `pad_in` do not alter `trap_word` until the next reset.
- R6: For exactly `WIN_CYCLES` cycles after the capturing edge, `pad_oe` is 2'b11 and `pad_out` is the bitwise inverse of the captured code.
- R7: After the window, `pad_out[i]` equals `~link_up[i]` and both `pad_oe` bits equal `led_en`.
- R8: With `led_en` low after the window, both pads are released (`pad_oe` = 2'b00) whatever the link state.
- R9: A new reset repeats the capture, so a different strap level held through that reset replaces the stored code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset; pads are released while low |
| led_en | input | 1 | LED enable control; 0 releases both pads after the window |
| link_up | input | 2 | Link status of the port tied to each pad (1 = link active) |
| pad_in | input | 2 | Pad input levels (index 1 feeds trap bit 10, index 0 feeds trap bit 9) |
| pad_oe | output | 2 | Pad output enables (1 = driven) |
| pad_out | output | 2 | Pad output values |
| trap_word | output | 16 | Read-only trap word holding the crystal code in bits 10:9 |

## Verification
The hardest case to reach is the capture edge itself. The stored code depends on the pad levels two flops back, and the pads must read as released at that edge. The bench holds each of the four strap patterns on `pad_in` through a multi-cycle reset. It releases reset on a falling edge and checks that the pads are still undriven in the half cycle before capture. It then flips `pad_in` during the display window to show that the stored code does not move. A final reset with a different strap pattern shows that the code is replaced.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    PH_HOLD = 2'd0,
    PH_SHOW = 2'd1,
    PH_LED  = 2'd2
  } phase_e;

  // Place a 2-bit crystal code into a trap word at bit position lsb.
  function automatic logic [15:0] trap_compose(input logic [15:0] base,
                                               input logic [1:0]  code,
                                               input int          lsb);
    logic [15:0] mask;
    mask = 16'(2'b11) << lsb;
    return (base & ~mask) | (16'(code) << lsb);
  endfunction

  // Pad levels shown during the post-reset window: active-low copy of the code.
  function automatic logic [1:0] show_level(input logic [1:0] code);
    return ~code;
  endfunction

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int NPAD = 2
) (
  input  logic            clk,
  input  logic [NPAD-1:0] pad_in,
  output logic [NPAD-1:0] lvl
);
  // Free-running so the strap level is settled when reset lifts.
  for (genvar i = 0; i < NPAD; i++) begin : g_pad
    logic s1, s2;
    always_ff @(posedge clk) begin
      s1 <= pad_in[i];
      s2 <= s1;
    end
    assign lvl[i] = s2;
  end
endmodule

// File: rtl/phase_seq.sv
module phase_seq
  import strap_pkg::*;
#(
  parameter int WIN_CYCLES = 77500
) (
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   cap_evt,
  output logic   in_window,
  output logic   in_led
);
  localparam int CW = $clog2(WIN_CYCLES + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_HOLD;
      cnt   <= '0;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          phase <= PH_SHOW;
          cnt   <= '0;
        end
        PH_SHOW: begin
          if (cnt == CW'(WIN_CYCLES - 1)) phase <= PH_LED;
          else                            cnt   <= cnt + 1'b1;
        end
        default: phase <= PH_LED;
      endcase
    end
  end

  assign cap_evt   = (phase == PH_HOLD);
  assign in_window = (phase == PH_SHOW);
  assign in_led    = (phase == PH_LED);
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
#(
  parameter int          FSEL_LSB  = 9,
  parameter logic [15:0] TRAP_BASE = 16'h79CF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [1:0]  lvl,
  output logic [1:0]  code,
  output logic [15:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    code <= 2'b00;
    else if (take) code <= lvl;
  end

  assign word = trap_compose(TRAP_BASE, code, FSEL_LSB);
endmodule

// File: rtl/pad_mux.sv
module pad_mux
  import strap_pkg::*;
#(
  parameter int NPAD = 2
) (
  input  phase_e          phase,
  input  logic [1:0]      code,
  input  logic            led_en,
  input  logic [NPAD-1:0] link_up,
  output logic [NPAD-1:0] pad_oe,
  output logic [NPAD-1:0] pad_out
);
  logic [1:0] shown;
  assign shown = show_level(code);

  for (genvar i = 0; i < NPAD; i++) begin : g_pad
    always_comb begin
      unique case (phase)
        PH_SHOW: begin
          pad_oe[i]  = 1'b1;
          pad_out[i] = shown[i];
        end
        PH_LED: begin
          pad_oe[i]  = led_en;
          pad_out[i] = ~link_up[i];
        end
        default: begin
          pad_oe[i]  = 1'b0;
          pad_out[i] = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/strap_led_pins.sv
module strap_led_pins
  import strap_pkg::*;
#(
  parameter int          WIN_CYCLES = 77500,
  parameter int          FSEL_LSB   = 9,
  parameter logic [15:0] TRAP_BASE  = 16'h79CF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        led_en,
  input  logic [1:0]  link_up,
  input  logic [1:0]  pad_in,
  output logic [1:0]  pad_oe,
  output logic [1:0]  pad_out,
  output logic [15:0] trap_word
);
  phase_e     phase;
  logic       cap_evt, in_window, in_led;
  logic [1:0] sync_lvl;
  logic [1:0] code;

  pad_sync #(.NPAD(2)) u_sync (
    .clk(clk), .pad_in(pad_in), .lvl(sync_lvl)
  );

  phase_seq #(.WIN_CYCLES(WIN_CYCLES)) u_seq (
    .clk(clk), .rst_n(rst_n), .phase(phase),
    .cap_evt(cap_evt), .in_window(in_window), .in_led(in_led)
  );

  strap_capture #(.FSEL_LSB(FSEL_LSB), .TRAP_BASE(TRAP_BASE)) u_cap (
    .clk(clk), .rst_n(rst_n), .take(cap_evt), .lvl(sync_lvl),
    .code(code), .word(trap_word)
  );

  pad_mux #(.NPAD(2)) u_mux (
    .phase(phase), .code(code), .led_en(led_en), .link_up(link_up),
    .pad_oe(pad_oe), .pad_out(pad_out)
  );
endmodule

// File: rtl/strap_led_pins_chk.sv
module strap_led_pins_chk #(
  parameter int WIN_CYCLES = 77500,
  parameter int FSEL_LSB   = 9
) (
  input logic        clk,
  input logic        rst_n,
  input logic        led_en,
  input logic [1:0]  link_up,
  input logic [1:0]  pad_oe,
  input logic [1:0]  pad_out,
  input logic [15:0] trap_word,
  input logic [1:0]  sync_lvl,
  input logic        cap_evt,
  input logic        in_window,
  input logic        in_led
);
  logic [31:0] win_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         win_seen <= '0;
    else if (in_window) win_seen <= win_seen + 1;
  end

  assert_released_in_reset_R1: assert property (@(posedge clk)
    !rst_n |-> pad_oe == 2'b00);

  assert_quiet_at_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> pad_oe == 2'b00);

  assert_code_from_pads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> trap_word[FSEL_LSB +: 2] == $past(sync_lvl));

  assert_code_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_evt |=> $stable(trap_word));

  assert_window_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_window |-> (pad_oe == 2'b11) && (pad_out == ~trap_word[FSEL_LSB +: 2]));

  assert_window_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_led) |-> win_seen == 32'(WIN_CYCLES));

  assert_led_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_led |-> (pad_out == ~link_up) && (pad_oe == {2{led_en}}));
endmodule

bind strap_led_pins strap_led_pins_chk #(
  .WIN_CYCLES(WIN_CYCLES), .FSEL_LSB(FSEL_LSB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .led_en(led_en), .link_up(link_up),
  .pad_oe(pad_oe), .pad_out(pad_out), .trap_word(trap_word),
  .sync_lvl(sync_lvl), .cap_evt(cap_evt), .in_window(in_window),
  .in_led(in_led)
);

// File: tb/sim_strap_led_pins.sv
`timescale 1ns/1ps
module sim_strap_led_pins;
  localparam int WIN = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        led_en = 1'b0;
  logic [1:0]  link_up = 2'b00;
  logic [1:0]  pad_in = 2'b00;
  logic [1:0]  pad_oe, pad_out;
  logic [15:0] trap_word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  strap_led_pins #(.WIN_CYCLES(WIN)) u0 (
    .clk(clk), .rst_n(rst_n), .led_en(led_en), .link_up(link_up),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out), .trap_word(trap_word)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [1:0] c);
    return 16'h79CF + 16'(c) * 16'd512;
  endfunction

  task automatic run_strap(input logic [1:0] c, input string rtag);
    logic [15:0] w;
    @(negedge clk);
    rst_n  = 1'b0;
    pad_in = c;
    // R1: pads released in reset for every LED/link combination
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      led_en  = k[2];
      link_up = k[1:0];
      #1 check(pad_oe == 2'b00, "R1", 16'(pad_oe), 16'h0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    #1 check(pad_oe == 2'b00, "R2", 16'(pad_oe), 16'h0);
    @(negedge clk);
    w = exp_word(c);
    #1 check(trap_word == w, rtag, trap_word, w);
    check(pad_oe == 2'b11 && pad_out == ~c, "R6", {pad_oe, pad_out}, {2'b11, ~c});
    // R5: pad levels change after capture
    pad_in  = ~c;
    led_en  = 1'b1;
    link_up = c ^ 2'b01;
    for (int k = 2; k <= WIN; k++) begin
      @(negedge clk);
      #1 check(pad_oe == 2'b11 && pad_out == ~c, "R6", {pad_oe, pad_out}, {2'b11, ~c});
    end
    @(negedge clk);
    #1 check(pad_oe == 2'b11 && pad_out == ~(c ^ 2'b01), "R6 R7 window end",
             {pad_oe, pad_out}, {2'b11, ~(c ^ 2'b01)});
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      led_en  = k[2];
      link_up = k[1:0];
      pad_in  = 2'(k);
      #1;
      if (k[2]) check(pad_oe == 2'b11 && pad_out == ~2'(k), "R7",
                      {pad_oe, pad_out}, {2'b11, ~2'(k)});
      else      check(pad_oe == 2'b00 && pad_out == ~2'(k), "R8",
                      {pad_oe, pad_out}, {2'b00, ~2'(k)});
      check(trap_word == w, "R5", trap_word, w);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int c = 0; c < 4; c++) run_strap(2'(c), "R3 R4");
    run_strap(2'b10, "R9");
    run_strap(2'b11, "R3 pad high");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule